// File: doc/BRIEF.md
# Relocatable System Control Register Window

This block holds the byte-wide system control registers of a small 8-bit microcontroller. It watches the CPU's 16-bit address bus and claims a 63-byte register window whose 4 KiB-aligned base can be moved at run time. A mapping register sets the window base and the base of a 256-byte internal RAM region, and the block raises a RAM select for that region wherever the register window does not cover it. The mode pins are sampled into a read-only mode register while reset is held. A watchdog service location recognises the arm-then-fire byte pair and emits a one-cycle service pulse for the external watchdog timer.

The bus is a single-cycle request port: `bus_cs` with `bus_we` marks a request, and every request is taken in the cycle it is presented. There is no back-pressure, so a requester never waits. Read data comes back one cycle later, qualified by `rd_valid`. A read outside the window returns `rd_valid` low and `rdata` zero. After reset is released the block spends one cycle pulsing `rst_out` to the peripherals. It then raises `run`, and only from that point does it accept bus requests.

Top module: `sysctl_window`

## Requirements
- R1: While reset is held and after it is released, the mapping register (offset 0x3D) reads 0x01. The window base is 0x1000 and the RAM base is 0x0000. General register bytes read 0x00.
- R2: `rst_out` is high for exactly the first cycle after `rst_n` rises. `run` rises on the next cycle. Requests presented before `run` is high have no effect.
- R3: The mode register (offset 0x3C) reads `{6'b0, smod, moda}`, loaded from `mode_pins[1]` (special) and `mode_pins[0]` (mode A) on clock edges while reset is held. The four modes are encoded as single-chip = 00, expanded = 01, bootstrap = 10 and test = 11. Pin changes after reset have no effect.
- R4: A write to a window offset below 0x3F stores the byte. A read returns that byte on `rdata` with `rd_valid` high in the cycle after the request.
- R5: Offsets 0x3F to 0xFFF of the window's 4 KiB page are outside the window. Reads there give `rd_valid` low and `rdata` 0, and writes there store nothing.
- R6: The low nibble of the mapping register selects the window base as nibble << 12. The new base applies from the cycle after the write, and the write itself decodes against the old base. A write that keeps the low nibble leaves the window where it is.
- R7: The high nibble of the mapping register sets `ram_base` to nibble << 12. `ram_sel` is high for a running request whose address is within 0x100 bytes of `ram_base` and outside the register window.
- R8: Writing 0xAA to the watchdog service offset 0x3A while it holds 0x55 makes `wdog_kick` high for exactly the following cycle, and the location then reads 0x00.
- R9: Any other write to offset 0x3A stores the written byte and gives no `wdog_kick`. This includes 0xAA written when the location does not hold 0x55.
- R10: Writes to the mode register are ignored.
- R11: With `bus_cs` low, no register changes, `rd_valid` stays low and `ram_sel` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_pins | input | 2 | Mode select pins: [0] mode A, [1] special |
| bus_cs | input | 1 | Request strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, one cycle after the request |
| rd_valid | output | 1 | Read hit the window last cycle |
| ram_sel | output | 1 | Current request targets internal RAM |
| win_base | output | 16 | Current register window base |
| ram_base | output | 16 | Current RAM base |
| wdog_kick | output | 1 | One-cycle watchdog service pulse |
| rst_out | output | 1 | One-cycle reset pulse to peripherals |
| run | output | 1 | Reset sequence finished, bus accepted |

## Verification
A corrupted mapping nibble shows on `win_base` or `ram_base` the next cycle. It also shows on every later request as `rd_valid` appearing at the wrong page and `ram_sel` asserting or dropping wrongly. A lost or spurious armed state in the watchdog location shows as a missing or extra `wdog_kick` one cycle after the 0xAA write, and as a wrong byte on the next read of 0x3A. A reset sequencer stuck in the wrong phase shows at once on `rst_out` and `run`, and one cycle later as requests that are accepted or dropped when they should not be.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int unsigned ADDR_W      = 16;
  localparam int unsigned DATA_W      = 8;
  localparam int unsigned PAGE_BITS   = 12;
  localparam int unsigned NIB_W       = ADDR_W - PAGE_BITS;
  localparam int unsigned WIN_SPAN    = 63;
  localparam int unsigned OFS_W       = $clog2(WIN_SPAN + 1);
  localparam int unsigned RAM_BITS    = 8;
  localparam logic [OFS_W-1:0] OFS_WDOG = 6'h3A;
  localparam logic [OFS_W-1:0] OFS_MODE = 6'h3C;
  localparam logic [OFS_W-1:0] OFS_MAP  = 6'h3D;
  localparam logic [DATA_W-1:0] WD_ARM  = 8'h55;
  localparam logic [DATA_W-1:0] WD_FIRE = 8'hAA;
  localparam logic [DATA_W-1:0] MAP_RST = 8'h01;

  typedef enum logic [1:0] {
    PH_HOLD  = 2'd0,
    PH_PULSE = 2'd1,
    PH_RUN   = 2'd2
  } phase_t;
endpackage

// File: rtl/sysctl_rstseq.sv
module sysctl_rstseq
  import sysctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_pins,
  output logic [1:0] mode,
  output logic       rst_out,
  output logic       run
);
  phase_t phase_q;
  logic [1:0] mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_HOLD;
      mode_q  <= mode_pins;
    end else begin
      case (phase_q)
        PH_HOLD:  phase_q <= PH_PULSE;
        PH_PULSE: phase_q <= PH_RUN;
        default:  phase_q <= PH_RUN;
      endcase
    end
  end

  assign mode    = mode_q;
  assign rst_out = (phase_q == PH_PULSE);
  assign run     = (phase_q == PH_RUN);

  AST_RST_PULSE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_out |=> (!rst_out && run)); // R2
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> $stable(mode_q)); // R3
endmodule

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
(
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NIB_W-1:0]  win_nib,
  input  logic [NIB_W-1:0]  ram_nib,
  output logic              win_hit,
  output logic [OFS_W-1:0]  ofs,
  output logic              ram_hit
);
  logic [PAGE_BITS-1:0] page_ofs;
  logic                 in_ram_page;

  assign page_ofs    = addr[PAGE_BITS-1:0];
  assign win_hit     = req && (addr[ADDR_W-1:PAGE_BITS] == win_nib)
                       && (page_ofs < PAGE_BITS'(WIN_SPAN));
  assign ofs         = page_ofs[OFS_W-1:0];
  assign in_ram_page = (addr[ADDR_W-1:PAGE_BITS] == ram_nib)
                       && (page_ofs[PAGE_BITS-1:RAM_BITS] == '0);
  assign ram_hit     = req && in_ram_page && !win_hit;
endmodule

// File: rtl/sysctl_wdog.sv
module sysctl_wdog
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] held,
  output logic              kick
);
  logic [DATA_W-1:0] held_q;
  logic              kick_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= '0;
      kick_q <= 1'b0;
    end else if (wr_en) begin
      if (wdata == WD_FIRE && held_q == WD_ARM) begin
        held_q <= '0;
        kick_q <= 1'b1;
      end else begin
        held_q <= wdata;
        kick_q <= 1'b0;
      end
    end else begin
      kick_q <= 1'b0;
    end
  end

  assign held = held_q;
  assign kick = kick_q;

  AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    kick_q |-> (held_q == '0)); // R8
  AST_KICK_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    kick_q |-> ($past(held_q) == WD_ARM)); // R8
  AST_KICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    kick_q |=> !kick_q); // R8
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_byte
);
  logic [DATA_W-1:0] slot [WIN_SPAN];

  for (genvar g = 0; g < WIN_SPAN; g++) begin : g_slot
    if (OFS_W'(g) == OFS_WDOG || OFS_W'(g) == OFS_MODE || OFS_W'(g) == OFS_MAP) begin : g_special
      assign slot[g] = '0;
    end else begin : g_store
      logic [DATA_W-1:0] byte_q;
      always_ff @(posedge clk) begin
        if (!rst_n)
          byte_q <= '0;
        else if (wr_en && ofs == OFS_W'(g))
          byte_q <= wdata;
      end
      assign slot[g] = byte_q;
    end
  end

  assign rd_byte = (ofs < OFS_W'(WIN_SPAN)) ? slot[ofs] : '0;
endmodule

// File: rtl/sysctl_window.sv
module sysctl_window
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_pins,
  input  logic              bus_cs,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid,
  output logic              ram_sel,
  output logic [ADDR_W-1:0] win_base,
  output logic [ADDR_W-1:0] ram_base,
  output logic              wdog_kick,
  output logic              rst_out,
  output logic              run
);
  logic [1:0]        mode;
  logic              req, win_hit, ram_hit;
  logic [OFS_W-1:0]  ofs;
  logic              wr_hit, rd_hit;
  logic [NIB_W-1:0]  win_nib_q, ram_nib_q;
  logic [DATA_W-1:0] wd_held, gen_byte, rd_mux;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;
  logic              map_wr;

  sysctl_rstseq u_rstseq (
    .clk(clk), .rst_n(rst_n), .mode_pins(mode_pins),
    .mode(mode), .rst_out(rst_out), .run(run)
  );

  assign req = bus_cs && run;

  sysctl_decode u_decode (
    .req(req), .addr(bus_addr), .win_nib(win_nib_q), .ram_nib(ram_nib_q),
    .win_hit(win_hit), .ofs(ofs), .ram_hit(ram_hit)
  );

  assign wr_hit = win_hit && bus_we;
  assign rd_hit = win_hit && !bus_we;
  assign map_wr = wr_hit && (ofs == OFS_MAP);

  // Window nibble reloads only on a real change; RAM nibble always follows.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_nib_q <= MAP_RST[NIB_W-1:0];
      ram_nib_q <= MAP_RST[DATA_W-1:NIB_W];
    end else if (map_wr) begin
      if (bus_wdata[NIB_W-1:0] != win_nib_q)
        win_nib_q <= bus_wdata[NIB_W-1:0];
      ram_nib_q <= bus_wdata[DATA_W-1:NIB_W];
    end
  end

  sysctl_wdog u_wdog (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_hit && (ofs == OFS_WDOG)), .wdata(bus_wdata),
    .held(wd_held), .kick(wdog_kick)
  );

  sysctl_regfile u_regfile (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_hit), .ofs(ofs),
    .wdata(bus_wdata), .rd_byte(gen_byte)
  );

  always_comb begin
    case (ofs)
      OFS_MAP:  rd_mux = {ram_nib_q, win_nib_q};
      OFS_MODE: rd_mux = {{(DATA_W-2){1'b0}}, mode};
      OFS_WDOG: rd_mux = wd_held;
      default:  rd_mux = gen_byte;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_hit;
      rdata_q  <= rd_hit ? rd_mux : '0;
    end
  end

  assign rdata    = rdata_q;
  assign rd_valid = rvalid_q;
  assign ram_sel  = ram_hit;
  assign win_base = {win_nib_q, {PAGE_BITS{1'b0}}};
  assign ram_base = {ram_nib_q, {PAGE_BITS{1'b0}}};

  AST_WIN_MOVES_ON_MAP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(win_nib_q) |-> $past(map_wr)); // R6
  AST_RAM_YIELDS_TO_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    ram_sel |-> !win_hit); // R7
  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_cs |=> !rd_valid); // R11
  AST_NO_REQ_BEFORE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !rd_valid); // R2
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rdata == '0)); // R5
endmodule

// File: tb/test_sysctl_window.sv
`timescale 1ns/1ps
module test_sysctl_window;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_pins = 2'b10;
  logic        bus_cs = 1'b0, bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  rdata;
  logic        rd_valid, ram_sel, wdog_kick, rst_out, run;
  logic [15:0] win_base, ram_base;

  int checks = 0, errs = 0;
  bit started = 0, done = 0;

  always #4 clk = ~clk;

  sysctl_window i_sysctl_window (
    .clk(clk), .rst_n(rst_n), .mode_pins(mode_pins),
    .bus_cs(bus_cs), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rdata(rdata), .rd_valid(rd_valid), .ram_sel(ram_sel),
    .win_base(win_base), .ram_base(ram_base), .wdog_kick(wdog_kick),
    .rst_out(rst_out), .run(run)
  );

  // Behavioural reference model
  bit [7:0] m_mem [63];
  bit [7:0] m_map, m_wd, m_rd;
  bit [1:0] m_mode;
  int       m_phase;
  bit       m_rst_out, m_run, m_rv, m_kick, m_hit;
  int       m_ofs;

  function automatic bit win_match(logic [15:0] a);
    return a[15:12] == m_map[3:0] && int'(a[11:0]) < 63;
  endfunction

  function automatic bit exp_ram();
    return bus_cs && m_run && bus_addr[15:12] == m_map[7:4]
           && bus_addr[11:8] == 4'h0 && !win_match(bus_addr);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = 8'h00;
      m_map = 8'h01; m_wd = 8'h00; m_mode = mode_pins; m_phase = 0;
      m_rst_out = 0; m_run = 0; m_rv = 0; m_rd = 0; m_kick = 0;
    end else begin
      m_kick = 0; m_rv = 0; m_rd = 0;
      m_hit = (m_phase == 2) && bus_cs && win_match(bus_addr);
      m_ofs = int'(bus_addr[11:0]);
      if (m_hit && !bus_we) begin
        m_rv = 1;
        if (m_ofs == 'h3D) m_rd = m_map;
        else if (m_ofs == 'h3C) m_rd = {6'b0, m_mode};
        else if (m_ofs == 'h3A) m_rd = m_wd;
        else m_rd = m_mem[m_ofs];
      end else if (m_hit && bus_we) begin
        if (m_ofs == 'h3D) m_map = bus_wdata;
        else if (m_ofs == 'h3A) begin
          if (bus_wdata == 8'hAA && m_wd == 8'h55) begin m_kick = 1; m_wd = 0; end
          else m_wd = bus_wdata;
        end else if (m_ofs != 'h3C) m_mem[m_ofs] = bus_wdata;
      end
      if (m_phase < 2) m_phase = m_phase + 1;
      m_rst_out = (m_phase == 1);
      m_run     = (m_phase == 2);
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) if (started && !done) begin
    chk(rst_out == m_rst_out, "R2 rst_out", rst_out, m_rst_out);
    chk(run == m_run, "R2 run", run, m_run);
    chk(rd_valid == m_rv, "R4 rd_valid", rd_valid, m_rv);
    chk(rdata == m_rd, "R4 rdata", rdata, m_rd);
    chk(wdog_kick == m_kick, "R8 wdog_kick", wdog_kick, m_kick);
    chk(win_base == {m_map[3:0], 12'h000}, "R6 win_base", win_base, {m_map[3:0], 12'h000});
    chk(ram_base == {m_map[7:4], 12'h000}, "R7 ram_base", ram_base, {m_map[7:4], 12'h000});
    #2;
    chk(ram_sel == exp_ram(), "R7 ram_sel", ram_sel, exp_ram());
  end

  task automatic drive(bit w, logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    bus_cs = 1; bus_we = w; bus_addr = a; bus_wdata = d;
  endtask

  task automatic idle();
    @(negedge clk);
    bus_cs = 0; bus_we = 0;
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    drive(1, a, d);
  endtask

  task automatic rd_chk(logic [15:0] a, bit ev, logic [7:0] ed, string tag);
    drive(0, a, 8'h00);
    @(negedge clk);
    bus_cs = 0;
    chk(rd_valid == ev, tag, rd_valid, ev);
    chk(rdata == ed, tag, rdata, ed);
  endtask

  task automatic do_reset(logic [1:0] pins);
    @(negedge clk);
    rst_n = 0; bus_cs = 0; mode_pins = pins;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    started = 1;
    chk(rst_out == 0 && run == 0, "R2 held in reset", {rst_out, run}, 0);
    chk(win_base == 16'h1000, "R1 window base at reset", win_base, 16'h1000);
    rst_n = 1;
    // request during the pulse cycle must be dropped (R2)
    bus_cs = 1; bus_we = 1; bus_addr = 16'h1000; bus_wdata = 8'h77;
    @(negedge clk);
    chk(rst_out == 1, "R2 pulse cycle", rst_out, 1);
    bus_cs = 0;
    @(negedge clk);
    chk(run == 1 && rst_out == 0, "R2 run after pulse", {run, rst_out}, 2);
    mode_pins = 2'b01;
    rd_chk(16'h1000, 1, 8'h00, "R2 early write dropped");
    rd_chk(16'h103D, 1, 8'h01, "R1 map reset value");
    rd_chk(16'h103C, 1, 8'h02, "R3 bootstrap mode captured");
    wr(16'h1005, 8'hA5); wr(16'h1000, 8'h3C); wr(16'h103E, 8'h81); idle();
    rd_chk(16'h1005, 1, 8'hA5, "R4 readback 05");
    rd_chk(16'h1000, 1, 8'h3C, "R4 readback 00");
    rd_chk(16'h103E, 1, 8'h81, "R4 readback 3E");
    wr(16'h103F, 8'h11); idle();
    rd_chk(16'h103F, 0, 8'h00, "R5 first offset outside");
    rd_chk(16'h1FFF, 0, 8'h00, "R5 page end outside");
    wr(16'h103C, 8'hFF); idle();
    rd_chk(16'h103C, 1, 8'h02, "R10 mode write ignored");
    @(negedge clk);
    bus_cs = 0; bus_we = 1; bus_addr = 16'h1005; bus_wdata = 8'h00;
    @(negedge clk);
    chk(rd_valid == 0, "R11 idle no read", rd_valid, 0);
    rd_chk(16'h1005, 1, 8'hA5, "R11 idle write ignored");
    // watchdog
    wr(16'h103A, 8'hAA); idle();
    chk(wdog_kick == 0, "R9 AA unarmed", wdog_kick, 0);
    rd_chk(16'h103A, 1, 8'hAA, "R9 AA stored");
    wr(16'h103A, 8'h55); wr(16'h103A, 8'h12); wr(16'h103A, 8'hAA); idle();
    chk(wdog_kick == 0, "R9 broken pair", wdog_kick, 0);
    wr(16'h103A, 8'h55); wr(16'h103A, 8'hAA); idle();
    chk(wdog_kick == 1, "R8 service pulse", wdog_kick, 1);
    @(negedge clk);
    chk(wdog_kick == 0, "R8 pulse one cycle", wdog_kick, 0);
    rd_chk(16'h103A, 1, 8'h00, "R8 cleared");
    // RAM select
    drive(0, 16'h0010, 0); #2;
    chk(ram_sel == 1, "R7 ram region", ram_sel, 1);
    drive(0, 16'h0100, 0); #2;
    chk(ram_sel == 0, "R7 past ram region", ram_sel, 0);
    wr(16'h103D, 8'h11); idle();
    drive(0, 16'h1005, 0); #2;
    chk(ram_sel == 0, "R7 window priority", ram_sel, 0);
    drive(0, 16'h1050, 0); #2;
    chk(ram_sel == 1, "R7 ram beside window", ram_sel, 1);
    idle();
    // relocation
    wr(16'h103D, 8'h13);
    drive(0, 16'h303D, 0);
    @(negedge clk); bus_cs = 0;
    chk(rd_valid == 1 && rdata == 8'h13, "R6 new base next cycle", rdata, 8'h13);
    rd_chk(16'h103D, 0, 8'h00, "R6 old base gone");
    rd_chk(16'h3005, 1, 8'hA5, "R6 bytes follow window");
    wr(16'h303D, 8'h23); idle();
    chk(win_base == 16'h3000 && ram_base == 16'h2000, "R6 same nibble keeps window", win_base, 16'h3000);
    rd_chk(16'h303D, 1, 8'h23, "R6 map readback");
    // second reset
    do_reset(2'b11);
    repeat (3) @(negedge clk);
    rd_chk(16'h103C, 1, 8'h03, "R3 test mode captured");
    rd_chk(16'h1005, 1, 8'h00, "R1 bytes cleared");
    rd_chk(16'h103D, 1, 8'h01, "R1 map restored");
    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errs++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule